// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is a right-shifting serial-in, parallel-out register with one output bit per stage. The bit entering the first stage is the AND of two serial data inputs. Either input can therefore act as an active-high enable for data arriving on the other. Every stage moves one place toward the far end on each rising clock edge.

An active-low clear empties the whole register at once, without waiting for a clock edge. It overrides both the clock and the data inputs.

The register is built from 8-stage sections whose count is a parameter. The sections are chained inside the block. The last stage of each section feeds one gating input of the next section, whose other gating input is tied high. All sections share the clock and the clear. The parallel output carries the newest bit at bit 0 and the oldest at the top.

Top module: `gated_sipo_shift`

## Requirements
- R1: While `clr_n` is low, every bit of `par_q` is 0 at once, with no clock edge needed, whatever the clock and serial inputs do.
- R2: On each rising `clk` edge with `clr_n` high, `par_q[0]` takes the value `ser_a & ser_b` sampled at that edge.
- R3: If `ser_a` or `ser_b` is 0 at a rising edge, a 0 enters `par_q[0]`.
- R4: Inside a section, on each rising edge every stage above the first takes the previous value of the stage below it. The top stage's old value goes only to the next section, if there is one.
- R5: At each section boundary, bit 8k of `par_q` (k ≥ 1) takes the previous value of bit 8k-1 on each rising edge. The unused gating input of that section is held at 1.
- R6: Starting from a cleared register, N_SECT×8 rising edges with `ser_a = ser_b = 1` make every bit of `par_q` equal to 1.
- R7: When `clr_n` rises with no clock edge, `par_q` stays all 0. The first shift happens on the next rising `clk` edge.
- R8: `par_q` is N_SECT×8 bits wide. Bit 0 holds the most recently entered value and bit i holds the value entered i edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | Serial data input A, ANDed with B |
| ser_b | input | 1 | Serial data input B, ANDed with A |
| par_q | output | N_SECT*8 | Parallel stage outputs, bit 0 newest |

## Verification
The bench builds the block with N_SECT = 3, a 24-bit register with two internal section boundaries. A single walking one can then be followed across both the 7→8 and the 15→16 cascade links. The ones-fill check runs for a full 24 edges. A clear is asserted in the middle of a clock period, then held across an edge with both serial inputs high, and then released away from any edge. This exercises the asynchronous path and the first shift that follows the release.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int unsigned SECT_W = 8;
  typedef logic [SECT_W-1:0] sect_vec_t;
endpackage

// File: rtl/gsr_entry_gate.sv
module gsr_entry_gate (
  input  logic gate_a,
  input  logic gate_b,
  output logic gate_y
);
  assign gate_y = gate_a & gate_b;
endmodule

// File: rtl/gsr_section.sv
module gsr_section #(
  parameter int unsigned W = gsr_pkg::SECT_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         din_a,
  input  logic         din_b,
  output logic [W-1:0] stage_q
);
  logic entry_bit;

  gsr_entry_gate u_gate (
    .gate_a(din_a),
    .gate_b(din_b),
    .gate_y(entry_bit)
  );

  // Asynchronous active-low clear; shift toward the top stage.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= {stage_q[W-2:0], entry_bit};
  end

  // R1: clear held low at an edge means the section is empty
  p_clear_empty_r1: assert property (@(posedge clk) !clr_n |-> (stage_q == '0))
    else $error("p_clear_empty_r1");

  // R2: first stage takes the AND of both inputs
  p_entry_and_r2: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (stage_q[0] == $past(din_a & din_b)))
    else $error("p_entry_and_r2");

  // R3: a low input blocks entry of a one
  p_zero_gate_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (!din_a || !din_b) |=> !stage_q[0])
    else $error("p_zero_gate_r3");

  // R4: each stage copies its lower neighbour
  p_stage_shift_r4: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (stage_q[W-1:1] == $past(stage_q[W-2:0])))
    else $error("p_stage_shift_r4");
endmodule

// File: rtl/gated_sipo_shift.sv
module gated_sipo_shift #(
  parameter int unsigned N_SECT = 2
) (
  input  logic                               clk,
  input  logic                               clr_n,
  input  logic                               ser_a,
  input  logic                               ser_b,
  output logic [N_SECT*gsr_pkg::SECT_W-1:0]  par_q
);
  localparam int unsigned SW      = gsr_pkg::SECT_W;
  localparam int unsigned TOTAL_W = N_SECT * SW;

  logic [N_SECT-1:0] link_a;
  logic [N_SECT-1:0] link_b;

  for (genvar k = 0; k < N_SECT; k++) begin : g_sect
    if (k == 0) begin : g_head
      assign link_a[k] = ser_a;
      assign link_b[k] = ser_b;
    end else begin : g_tail
      // Previous section's top stage feeds A; B is tied high.
      assign link_a[k] = par_q[k*SW-1];
      assign link_b[k] = 1'b1;

      // R5: section boundary carries the previous top stage
      p_cascade_link_r5: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (par_q[k*SW] == $past(par_q[k*SW-1])))
        else $error("p_cascade_link_r5");
    end

    gsr_section #(.W(SW)) u_sect (
      .clk    (clk),
      .clr_n  (clr_n),
      .din_a  (link_a[k]),
      .din_b  (link_b[k]),
      .stage_q(par_q[k*SW +: SW])
    );
  end

  // R8: output width matches the section count
  initial begin
    p_width_r8: assert ($bits(par_q) == TOTAL_W) else $error("p_width_r8");
  end
endmodule

// File: tb/test_gated_sipo_shift.sv
module test_gated_sipo_shift;
  localparam int CLK_PERIOD = 10;
  localparam int N_SECT = 3;
  localparam int W = N_SECT * 8;

  typedef struct {
    logic [W-1:0] vec;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic ser_a = 1'b0;
  logic ser_b = 1'b0;
  logic [W-1:0] par_q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  exp_t sb_q[$];
  bit done = 1'b0;

  gated_sipo_shift #(.N_SECT(N_SECT)) i_gated_sipo_shift (
    .clk(clk), .clr_n(clr_n), .ser_a(ser_a), .ser_b(ser_b), .par_q(par_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_now(input logic [W-1:0] exp, input string tag);
    checks++;
    if (par_q !== exp) begin
      errors++;
      $display("FAIL %s: par_q=%h expected=%h", tag, par_q, exp);
    end
  endtask

  // Driver: one call owns one rising edge.
  task automatic shift(input logic a, input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    ser_a = a;
    ser_b = b;
    model = {model[W-2:0], a & b};
    e.vec = model;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares a quarter period after each edge.
  always @(posedge clk) begin
    if (clr_n && sb_q.size() > 0) begin
      exp_t e;
      #(CLK_PERIOD/4);
      e = sb_q.pop_front();
      check_now(e.vec, e.tag);
    end
  end

  // Clear in mid-period, hold it across an edge, release off-edge.
  task automatic do_clear();
    @(posedge clk);
    #(3*CLK_PERIOD/8);
    clr_n = 1'b0;
    #1;
    check_now('0, "R1 async clear mid-period");
    ser_a = 1'b1;
    ser_b = 1'b1;
    @(posedge clk);
    #1;
    check_now('0, "R1 clear overrides clock and data");
    @(posedge clk);
    #(CLK_PERIOD/8);
    clr_n = 1'b1;
    #1;
    check_now('0, "R7 release without edge keeps zero");
    model = '0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check_now('0, "R1 reset state");
    @(posedge clk);
    #(CLK_PERIOD/8);
    clr_n = 1'b1;
    #1;
    check_now('0, "R7 initial release");

    // R2/R8: single one enters at bit 0; R4/R5: walks across both boundaries
    shift(1'b1, 1'b1, "R2 one entry at bit0 R7 first shift");
    for (int i = 1; i < W; i++) shift(1'b0, 1'b0, "R4 R5 walking one");
    shift(1'b0, 1'b0, "R4 one leaves top");

    // R3: gating combinations
    shift(1'b1, 1'b1, "R2 pattern");
    shift(1'b0, 1'b1, "R3 a low blocks");
    shift(1'b1, 1'b0, "R3 b low blocks");
    shift(1'b1, 1'b1, "R2 pattern");
    shift(1'b0, 1'b0, "R3 both low");
    for (int i = 0; i < 2 * W; i++)
      shift(i[0] | i[2], i[1] | i[0], "R3 R8 mixed gating");

    // R6: fill with ones from cleared
    do_clear();
    for (int i = 0; i < W; i++) shift(1'b1, 1'b1, "R6 fill ones");
    @(negedge clk);
    ser_a = 1'b0;
    ser_b = 1'b0;
    #1;
    checks++;
    if (par_q !== {W{1'b1}}) begin
      errors++;
      $display("FAIL R6: par_q=%h expected=%h", par_q, {W{1'b1}});
    end

    // R1 mid-run then R7 first shift after release
    do_clear();
    shift(1'b1, 1'b1, "R7 first shift after release");
    shift(1'b0, 1'b1, "R3 after release");
    @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected=finish actual=hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule